// File: doc/BRIEF.md
# System Management Interface Target

This block is the controller-side end of a three-register byte interface between a host and a management controller. The host writes a data byte and a control code, then sets the busy flag. After a set delay the target carries out that one step and clears busy. The host polls the busy flag and then reads a status code and the data register. A request arrives one byte per step and is stored in a request buffer. The local side sees the finished request through a read port and fills a response buffer. The host then draws the response out one byte per step. The target marks the final byte with its own status code, so no length field is needed.

The controller has five states. ST_READY accepts get-status and write-start. ST_WRITING accepts write-next and write-end. ST_WAIT_RSP waits for the local side to commit a response. ST_RESPONSE hands out bytes on read-start or read-next. ST_LAST waits for read-end. The transitions are:
- ST_READY goes to ST_WRITING on write-start.
- ST_WRITING goes to ST_WAIT_RSP on a write-end that fits the buffer. It goes to ST_READY on a write-end that overflows it.
- ST_WAIT_RSP goes to ST_RESPONSE when the local side pulses `rsp_done`.
- ST_RESPONSE goes to ST_LAST when the final byte is handed out.
- ST_LAST goes to ST_READY on read-end.
- Any state goes to ST_READY on a control code that is out of sequence.

Top module: `sysmgmt_target`

## Requirements
- R1: Register offsets are data at 0, control (write) / status (read) at 1, and flags at 2. A read strobe makes `host_rdata` show the addressed register in the cycle after the strobe. Offset 3 reads 0x00.
- R2: Writing a flags byte with bit 0 set makes BSY (flags bit 0) read 1 for exactly BUSY_CYCLES cycles. The pending step completes when BSY clears. Host writes to data, control or flags made while BSY is 1 are ignored.
- R3: A status code is 0xC0 ORed with an operation code (0 ready, 1/2/3 write start/next/end, 4/5/6 read start/next/end). A get-status control code (0x40) in ST_READY returns 0xC0 and leaves the data register unchanged.
- R4: Control codes 0x41, 0x42 and 0x43 each store the data register byte into the request buffer, in order, and return 0xC1, 0xC2 and 0xC3. After a good write-end, `req_pending` is 1, `req_len` gives the byte count, and `req_rdata` returns the byte at `req_raddr`.
- R5: After write-end the data register holds 0x00 if the request fits in DEPTH bytes. If the request is longer than DEPTH, it holds 0x05, the target returns to ST_READY, and no request is raised. A request of exactly DEPTH bytes is accepted.
- R6: Flags bit 6 (TX ready) is 1 in ST_READY and ST_WRITING. Flags bit 7 (RX ready) is 1 only in ST_RESPONSE, from the cycle after `rsp_done` until the final byte is handed out.
- R7: Read-start (0x44) when no byte has been read, or read-next (0x45) after at least one, places the next response byte in the data register and returns 0xC4 or 0xC5 respectively. On the final byte it returns 0xC6 instead.
- R8: Read-end (0x46) in ST_LAST returns status 0xC0 and puts the local error code given with `rsp_done` in the data register. The target is then in ST_READY.
- R9: Any control code that is not legal in the current state returns status 0xC0 and data 0x02, and the target goes to ST_READY.
- R10: Flags bits 4, 3 and 2 follow `attn_smi`, `attn_evm` and `attn_sms`. Bits 5 and 1 are always 0, so flags never reads 0xFF.
- R11: `rsp_push` and `rsp_done` have no effect outside ST_WAIT_RSP.
- R12: After reset the flags read 0x40, status reads 0xC0, data reads 0x00 and `req_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| attn_sms | input | 1 | Local message available (flags bit 2) |
| attn_evm | input | 1 | Local event available (flags bit 3) |
| attn_smi | input | 1 | Local interrupt request (flags bit 4) |
| req_pending | output | 1 | A complete request waits for a response |
| req_len | output | CW | Stored request byte count |
| req_raddr | input | AW | Request buffer read index |
| req_rdata | output | 8 | Request byte at req_raddr |
| rsp_push | input | 1 | Append rsp_byte to the response |
| rsp_byte | input | 8 | Response byte |
| rsp_done | input | 1 | Commit the response |
| rsp_err | input | 8 | Completion error code, captured on rsp_done |

## Verification
BSY is set at the write edge and stays readable as 1 for BUSY_CYCLES polls; the poll that follows is the first to read it clear. The bench counts these polls exactly once and then polls to completion. Every register read lands in `host_rdata` one cycle after its strobe. The bench therefore samples a cycle after each strobe, at the falling edge, and the status and data checks are taken only after BSY has dropped. `req_pending`, `req_len` and the RX flag change at the edge that ends the step or takes `rsp_done`, so the bench checks them on the next falling edge or later.

// File: rtl/sysmgmt_tgt_pkg.sv
package sysmgmt_tgt_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_WRITING,
        ST_WAIT_RSP,
        ST_RESPONSE,
        ST_LAST
    } tgt_state_e;

    // Register offsets seen by the host
    localparam logic [1:0] ADR_DATA  = 2'd0;
    localparam logic [1:0] ADR_CS    = 2'd1;
    localparam logic [1:0] ADR_FLAGS = 2'd2;

    // Operation field (bits 3:0) of control and status codes
    localparam logic [3:0] OP_IDLE     = 4'd0;
    localparam logic [3:0] OP_WR_START = 4'd1;
    localparam logic [3:0] OP_WR_NEXT  = 4'd2;
    localparam logic [3:0] OP_WR_END   = 4'd3;
    localparam logic [3:0] OP_RD_START = 4'd4;
    localparam logic [3:0] OP_RD_NEXT  = 4'd5;
    localparam logic [3:0] OP_RD_END   = 4'd6;

    localparam logic [7:0] CTL_BASE = 8'h40;
    localparam logic [7:0] STS_BASE = 8'hC0;

    localparam logic [7:0] ERR_NONE        = 8'h00;
    localparam logic [7:0] ERR_ILLEGAL_CTL = 8'h02;
    localparam logic [7:0] ERR_BUF_FULL    = 8'h05;

    function automatic logic [7:0] ctl_code(input logic [3:0] op);
        return CTL_BASE | {4'h0, op};
    endfunction

    function automatic logic [7:0] sts_code(input logic [3:0] op);
        return STS_BASE | {4'h0, op};
    endfunction

endpackage

// File: rtl/sysmgmt_busy_timer.sv
module sysmgmt_busy_timer #(
    parameter int BUSY_CYCLES = 3,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic busy_o,
    output logic fire_o
);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign fire_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (fire_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (set_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(BUSY_CYCLES - 1);
        end
    end

endmodule

// File: rtl/sysmgmt_byte_buf.sv
module sysmgmt_byte_buf #(
    parameter int DEPTH = 80,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [7:0]    byte_i,
    output logic [CW-1:0] cnt_o,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wr_idx;
    logic          accept;

    assign wr_idx  = clr_i ? '0 : cnt_q[AW-1:0];
    assign accept  = push_i && (clr_i || (int'(cnt_q) < DEPTH));
    assign cnt_o   = cnt_q;
    assign rdata_o = (int'(raddr_i) < DEPTH) ? mem[raddr_i] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= push_i ? CW'(1) : '0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_idx] <= byte_i;
        end
    end

endmodule

// File: rtl/sysmgmt_target.sv
module sysmgmt_target
    import sysmgmt_tgt_pkg::*;
#(
    parameter int DEPTH = 80,
    parameter int BUSY_CYCLES = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          attn_sms,
    input  logic          attn_evm,
    input  logic          attn_smi,
    output logic          req_pending,
    output logic [CW-1:0] req_len,
    input  logic [AW-1:0] req_raddr,
    output logic [7:0]    req_rdata,
    input  logic          rsp_push,
    input  logic [7:0]    rsp_byte,
    input  logic          rsp_done,
    input  logic [7:0]    rsp_err
);

    tgt_state_e    state_q, nxt_state;
    logic [7:0]    status_q, status_n;
    logic [7:0]    data_q, data_n;
    logic [7:0]    ctrl_q, ctrl_n;
    logic [7:0]    err_q, err_n;
    logic [7:0]    rdata_q;
    logic          ovf_q, ovf_n;
    logic [CW-1:0] rd_pos_q, rd_pos_n;

    logic          busy_w, fire_w, set_busy;
    logic          req_clr, req_push, rsp_clr, rsp_acc, bad;
    logic [CW-1:0] req_cnt, rsp_cnt;
    logic [7:0]    rsp_rdata;
    logic [7:0]    flags;
    logic          last_byte;
    logic          host_free_wr;

    assign host_free_wr = host_wr && !busy_w;
    assign set_busy     = host_free_wr && (host_addr == ADR_FLAGS) && host_wdata[0];

    sysmgmt_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_busy),
        .busy_o (busy_w),
        .fire_o (fire_w)
    );

    sysmgmt_byte_buf #(.DEPTH(DEPTH)) u_req_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (req_clr),
        .push_i  (req_push),
        .byte_i  (data_q),
        .cnt_o   (req_cnt),
        .raddr_i (req_raddr),
        .rdata_o (req_rdata)
    );

    sysmgmt_byte_buf #(.DEPTH(DEPTH)) u_rsp_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rsp_clr),
        .push_i  (rsp_acc),
        .byte_i  (rsp_byte),
        .cnt_o   (rsp_cnt),
        .raddr_i (rd_pos_q[AW-1:0]),
        .rdata_o (rsp_rdata)
    );

    assign last_byte   = ({1'b0, rd_pos_q} + 1'b1) >= {1'b0, rsp_cnt};
    assign req_pending = (state_q == ST_WAIT_RSP);
    assign req_len     = req_cnt;
    assign host_rdata  = rdata_q;

    // Flags layout: RX ready, TX ready, 0, SMI, EVM, SMS, 0, BSY
    assign flags = {(state_q == ST_RESPONSE),
                    (state_q == ST_READY) || (state_q == ST_WRITING),
                    1'b0, attn_smi, attn_evm, attn_sms, 1'b0, busy_w};

    always_comb begin
        nxt_state = state_q;
        status_n  = status_q;
        data_n    = data_q;
        ctrl_n    = ctrl_q;
        err_n     = err_q;
        ovf_n     = ovf_q;
        rd_pos_n  = rd_pos_q;
        req_clr   = 1'b0;
        req_push  = 1'b0;
        rsp_clr   = 1'b0;
        rsp_acc   = 1'b0;
        bad       = 1'b0;

        if (host_free_wr && host_addr == ADR_DATA) data_n = host_wdata;
        if (host_free_wr && host_addr == ADR_CS)   ctrl_n = host_wdata;

        if (fire_w) begin
            unique case (state_q)
                ST_READY: begin
                    if (ctrl_q == ctl_code(OP_IDLE)) begin
                        status_n = sts_code(OP_IDLE);
                    end else if (ctrl_q == ctl_code(OP_WR_START)) begin
                        req_clr   = 1'b1;
                        req_push  = 1'b1;
                        ovf_n     = 1'b0;
                        status_n  = sts_code(OP_WR_START);
                        nxt_state = ST_WRITING;
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_WRITING: begin
                    if (ctrl_q == ctl_code(OP_WR_NEXT)) begin
                        req_push = 1'b1;
                        status_n = sts_code(OP_WR_NEXT);
                        if (int'(req_cnt) == DEPTH) ovf_n = 1'b1;
                    end else if (ctrl_q == ctl_code(OP_WR_END)) begin
                        req_push = 1'b1;
                        status_n = sts_code(OP_WR_END);
                        if (ovf_q || int'(req_cnt) == DEPTH) begin
                            data_n    = ERR_BUF_FULL;
                            nxt_state = ST_READY;
                        end else begin
                            data_n    = ERR_NONE;
                            rsp_clr   = 1'b1;
                            nxt_state = ST_WAIT_RSP;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_WAIT_RSP: begin
                    bad = 1'b1;
                end
                ST_RESPONSE: begin
                    if ((ctrl_q == ctl_code(OP_RD_START) && rd_pos_q == '0) ||
                        (ctrl_q == ctl_code(OP_RD_NEXT)  && rd_pos_q != '0)) begin
                        data_n = (rsp_cnt == '0) ? 8'h00 : rsp_rdata;
                        if (last_byte) begin
                            status_n  = sts_code(OP_RD_END);
                            nxt_state = ST_LAST;
                        end else begin
                            status_n = (rd_pos_q == '0) ? sts_code(OP_RD_START)
                                                        : sts_code(OP_RD_NEXT);
                            rd_pos_n = rd_pos_q + 1'b1;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_LAST: begin
                    if (ctrl_q == ctl_code(OP_RD_END)) begin
                        status_n  = sts_code(OP_IDLE);
                        data_n    = err_q;
                        nxt_state = ST_READY;
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
            if (bad) begin
                status_n  = sts_code(OP_IDLE);
                data_n    = ERR_ILLEGAL_CTL;
                nxt_state = ST_READY;
            end
        end else if (state_q == ST_WAIT_RSP) begin
            rsp_acc = rsp_push;
            if (rsp_done) begin
                err_n     = rsp_err;
                rd_pos_n  = '0;
                nxt_state = ST_RESPONSE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= nxt_state;
    end

    // Register file and host read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STS_BASE;
            data_q   <= 8'h00;
            ctrl_q   <= 8'h00;
            err_q    <= 8'h00;
            ovf_q    <= 1'b0;
            rd_pos_q <= '0;
            rdata_q  <= 8'h00;
        end else begin
            status_q <= status_n;
            data_q   <= data_n;
            ctrl_q   <= ctrl_n;
            err_q    <= err_n;
            ovf_q    <= ovf_n;
            rd_pos_q <= rd_pos_n;
            if (host_rd) begin
                case (host_addr)
                    ADR_DATA:  rdata_q <= data_q;
                    ADR_CS:    rdata_q <= status_q;
                    ADR_FLAGS: rdata_q <= flags;
                    default:   rdata_q <= 8'h00;
                endcase
            end
        end
    end

endmodule

// File: rtl/sysmgmt_target_chk.sv
module sysmgmt_target_chk #(
    parameter int BUSY_CYCLES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic [7:0] host_rdata,
    input logic       req_pending,
    input logic       busy
);

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R2: BSY never stays set longer than BUSY_CYCLES cycles
    assert_bsy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < BUSY_CYCLES));

    // R3: every status read carries the status marker and stream field
    assert_status_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd1) |=> (host_rdata[7:5] == 3'b110));

    // R6: no RX ready while the request is still waiting for a response
    assert_no_rx_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd2 && req_pending) |=> !host_rdata[7]);

    // R10: flags never read back as all ones
    assert_flags_not_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd2) |=> (host_rdata != 8'hFF));

endmodule

bind sysmgmt_target sysmgmt_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_rdata  (host_rdata),
    .req_pending (req_pending),
    .busy        (busy_w)
);

// File: tb/sysmgmt_target_test.sv
module sysmgmt_target_test;

    localparam int DEPTH = 80;
    localparam int BUSY_CYCLES = 3;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          attn_sms = 1'b0, attn_evm = 1'b0, attn_smi = 1'b0;
    logic          req_pending;
    logic [CW-1:0] req_len;
    logic [AW-1:0] req_raddr = '0;
    logic [7:0]    req_rdata;
    logic          rsp_push = 1'b0, rsp_done = 1'b0;
    logic [7:0]    rsp_byte = '0, rsp_err = '0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] st;
        logic [7:0] dat;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    sysmgmt_target #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .attn_sms(attn_sms), .attn_evm(attn_evm), .attn_smi(attn_smi),
        .req_pending(req_pending), .req_len(req_len), .req_raddr(req_raddr),
        .req_rdata(req_rdata), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
        .rsp_done(rsp_done), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // All tasks start and end at a falling edge
    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] f;
        for (int i = 0; i < 64; i++) begin
            hrd(2'd2, f);
            if (!f[0]) return;
        end
        check("R2 busy never cleared", 32'd1, 32'd0);
    endtask

    // Monitor: pops the oldest expected result and compares
    task automatic monitor(input logic [7:0] st, input logic [7:0] dat);
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " status"}, st, e.st);
        check({e.tag, " data"}, dat, e.dat);
    endtask

    // Driver: queues the expectation, then runs one host step
    task automatic step(input logic [7:0] ctl, input logic [7:0] din,
                        input logic [7:0] est, input logic [7:0] edat, input string tag);
        logic [7:0] st, dat;
        exp_q.push_back('{st: est, dat: edat, tag: tag});
        hwr(2'd0, din);
        hwr(2'd1, ctl);
        hwr(2'd2, 8'h01);
        wait_idle();
        hrd(2'd1, st);
        hrd(2'd0, dat);
        monitor(st, dat);
    endtask

    task automatic lpush(input logic [7:0] b);
        rsp_byte = b; rsp_push = 1'b1;
        @(negedge clk);
        rsp_push = 1'b0;
    endtask

    task automatic ldone(input logic [7:0] e);
        rsp_err = e; rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
    endtask

    task automatic chk_flags(input logic [7:0] e, input string tag);
        logic [7:0] f;
        hrd(2'd2, f);
        check(tag, f, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL [R2 watchdog] actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] req1 [3];
        logic [7:0] rsp1 [4];
        req1 = '{8'h18, 8'h01, 8'h22};
        rsp1 = '{8'hA5, 8'h5A, 8'h3C, 8'h99};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk_flags(8'h40, "R12 flags after reset");
        hrd(2'd1, v); check("R12 status after reset", v, 8'hC0);
        hrd(2'd0, v); check("R12 data after reset", v, 8'h00);
        check("R12 req_pending after reset", req_pending, 1'b0);
        hrd(2'd3, v); check("R1 offset 3 reads zero", v, 8'h00);

        // R2: BSY holds for exactly BUSY_CYCLES polls
        hwr(2'd0, 8'h3A);
        hwr(2'd1, 8'h40);
        hwr(2'd2, 8'h01);
        hwr(2'd0, 8'h77);  // ignored: busy
        hwr(2'd1, 8'h45);  // ignored: busy
        hrd(2'd2, v);
        check("R2 busy still set", v[0], 1'b1);
        wait_idle();
        hrd(2'd1, v); check("R3 get-status under busy writes", v, 8'hC0);
        hrd(2'd0, v); check("R2 data write while busy ignored", v, 8'h3A);

        hwr(2'd2, 8'h01);
        for (int i = 0; i < BUSY_CYCLES; i++) begin
            hrd(2'd2, v);
            check("R2 BSY set during window", v[0], 1'b1);
        end
        hrd(2'd2, v);
        check("R2 BSY clear after window", v[0], 1'b0);

        // R3 get-status keeps host data
        step(8'h40, 8'h5E, 8'hC0, 8'h5E, "R3 get-status");

        // R4/R5 first transaction
        step(8'h41, req1[0], 8'hC1, req1[0], "R4 write-start");
        chk_flags(8'h40, "R6 TX ready while writing");
        step(8'h42, req1[1], 8'hC2, req1[1], "R4 write-next");
        step(8'h43, req1[2], 8'hC3, 8'h00, "R5 write-end ok");
        check("R4 req_pending", req_pending, 1'b1);
        check("R4 req_len", req_len, 3);
        for (int i = 0; i < 3; i++) begin
            req_raddr = AW'(i);
            #1;
            check("R4 request byte", req_rdata, req1[i]);
        end
        chk_flags(8'h00, "R6 no TX/RX while pending");
        for (int i = 0; i < 4; i++) lpush(rsp1[i]);
        ldone(8'h00);
        check("R6 req_pending dropped", req_pending, 1'b0);
        chk_flags(8'h80, "R6 RX ready after commit");
        step(8'h44, 8'h00, 8'hC4, rsp1[0], "R7 read-start");
        step(8'h45, 8'h00, 8'hC5, rsp1[1], "R7 read-next");
        step(8'h45, 8'h00, 8'hC5, rsp1[2], "R7 read-next 2");
        step(8'h45, 8'h00, 8'hC6, rsp1[3], "R7 final byte");
        chk_flags(8'h00, "R6 RX cleared after final");
        step(8'h46, 8'h00, 8'hC0, 8'h00, "R8 read-end");
        chk_flags(8'h40, "R6 TX ready back in ready");

        // R10 attention bits
        attn_sms = 1'b1; attn_evm = 1'b1; attn_smi = 1'b1;
        chk_flags(8'h5C, "R10 attention bits");
        attn_evm = 1'b0;
        chk_flags(8'h54, "R10 evm cleared");
        attn_sms = 1'b0; attn_smi = 1'b0;

        // R11 pushes outside waiting ignored; R8 error code
        lpush(8'h33);
        ldone(8'h09);
        check("R11 done in ready ignored", req_pending, 1'b0);
        chk_flags(8'h40, "R11 no RX from stray done");
        step(8'h41, 8'h2C, 8'hC1, 8'h2C, "R4 write-start two");
        step(8'h43, 8'h07, 8'hC3, 8'h00, "R5 write-end two");
        check("R4 req_len two", req_len, 2);
        lpush(8'h61);
        ldone(8'h04);
        lpush(8'hEE);
        step(8'h44, 8'h00, 8'hC6, 8'h61, "R11 single byte response");
        step(8'h46, 8'h00, 8'hC0, 8'h04, "R8 error code returned");

        // R9 out-of-sequence control codes
        step(8'h45, 8'h11, 8'hC0, 8'h02, "R9 read-next in ready");
        step(8'h41, 8'h01, 8'hC1, 8'h01, "R9 setup write-start");
        step(8'h44, 8'h00, 8'hC0, 8'h02, "R9 read-start while writing");
        step(8'h42, 8'h00, 8'hC0, 8'h02, "R9 write-next after abort");
        step(8'h46, 8'h00, 8'hC0, 8'h02, "R9 read-end in ready");

        // R5 exactly DEPTH bytes accepted
        step(8'h41, 8'h00, 8'hC1, 8'h00, "R5 full start");
        for (int i = 1; i < DEPTH - 1; i++) begin
            exp_q.push_back('{st: 8'hC2, dat: 8'(i), tag: "R5 full next"});
            hwr(2'd0, 8'(i)); hwr(2'd1, 8'h42); hwr(2'd2, 8'h01);
            wait_idle();
            hrd(2'd1, v);
            begin
                logic [7:0] d;
                hrd(2'd0, d);
                monitor(v, d);
            end
        end
        step(8'h43, 8'hFE, 8'hC3, 8'h00, "R5 exactly DEPTH accepted");
        check("R5 req_len DEPTH", req_len, DEPTH);
        req_raddr = AW'(DEPTH - 1);
        #1;
        check("R5 last stored byte", req_rdata, 8'hFE);
        step(8'h40, 8'h00, 8'hC0, 8'h02, "R9 get-status while waiting");
        check("R9 pending cleared", req_pending, 1'b0);

        // R5 DEPTH+1 bytes overflow
        step(8'h41, 8'h00, 8'hC1, 8'h00, "R5 over start");
        for (int i = 1; i < DEPTH; i++) begin
            logic [7:0] d;
            exp_q.push_back('{st: 8'hC2, dat: 8'h5A, tag: "R5 over next"});
            hwr(2'd0, 8'h5A); hwr(2'd1, 8'h42); hwr(2'd2, 8'h01);
            wait_idle();
            hrd(2'd1, v);
            hrd(2'd0, d);
            monitor(v, d);
        end
        step(8'h43, 8'h5A, 8'hC3, 8'h05, "R5 overflow error");
        check("R5 no request on overflow", req_pending, 1'b0);
        chk_flags(8'h40, "R5 back to ready");

        finish_run();
    end

endmodule